// File: doc/BRIEF.md
# Sixteen-Bit Arithmetic/Logic Unit with Flag Register

This block takes two operands and carries out one of ten arithmetic, logic or shift operations on them, or one of six commands that set or clear a control flag. Its result output is combinational. Six status flags are produced beside the result: carry, parity, auxiliary carry, zero, sign and overflow. These flags, together with three control flags (trap, interrupt enable and direction), sit in a registered 16-bit flag word. A byte/word select narrows the operation to the low eight bits of each operand.

A sequencer uses the block by presenting operands and an operation code each cycle. When the new flags should be kept, it raises the flag-update enable, and the flag word then takes its new value on the next rising clock edge. The control flags change only through their dedicated commands, so software state such as interrupt enable survives any amount of arithmetic.

Top module: `flag_alu`

## Requirements
- R1: An active-low reset clears the whole flag word to 0x0000. Bits 1, 3, 5 and 12 to 15 of the flag word always read as zero. Flag positions: CF=0, PF=2, AF=4, ZF=6, SF=7, TF=8, IF=9, DF=10, OF=11.
- R2: The flag word changes only on a rising clock edge on which flagWe is high. When flagWe is low, every flag keeps its value, whatever the operation code.
- R3: Opcode 0 adds, 1 subtracts (opA minus opB), 2 increments opA and 3 decrements opA, each modulo the active width. For add, CF becomes the carry out of the top bit. For subtract, CF becomes the borrow, which is 1 when opA is below opB unsigned. Increment and decrement leave CF unchanged.
- R4: For opcodes 0 to 3, AF becomes the carry or borrow that passes from bit 3 into bit 4.
- R5: For opcodes 0 to 3, OF becomes 1 exactly when the two's-complement result falls outside the signed range of the active width.
- R6: For opcodes 0 to 9, ZF is 1 when the result is zero and SF copies the top bit of the active width. PF is 1 when result bits 7:0 hold an even number of ones.
- R7: Opcode 4 gives the bitwise complement of opA, and opcodes 5, 6 and 7 give AND, OR and XOR of the operands. Each of these clears CF and OF and leaves AF unchanged.
- R8: Opcode 8 shifts opA left by one and opcode 9 shifts it right by one, filling with zero. CF takes the bit shifted out. OF is 1 when the top bit of the result differs from the top bit of opA. AF is unchanged.
- R9: When byteMode is high, only bits 7:0 of the operands are used and result bits 15:8 are zero. Carry, sign, zero and overflow then refer to bit 7 and to the carry out of bit 7.
- R10: Opcodes 10 and 11 set and clear IF, 12 and 13 set and clear TF, and 14 and 15 set and clear DF. These commands drive a zero result and leave all other flags unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| opA | input | 16 | First operand |
| opB | input | 16 | Second operand |
| opSel | input | 4 | Operation code |
| byteMode | input | 1 | 1 selects byte width, 0 selects word width |
| flagWe | input | 1 | Flag-update enable |
| result | output | 16 | Combinational result |
| flagWord | output | 16 | Registered flag word |

## Verification
The assertions compare the flags of one edge with the result and operation code of the cycle before. They therefore assume that the operands, opSel and byteMode stay constant between two rising edges. The bench changes inputs only on falling edges and holds them through the following rising edge, so each sampled cycle sees a single, stable operation. Reset is asserted only at the start of the run, so no property window crosses a reset.

// File: rtl/flag_alu_pkg.sv
package flag_alu_pkg;

  localparam int FLAG_W = 16;
  localparam int CF_POS = 0;
  localparam int PF_POS = 2;
  localparam int AF_POS = 4;
  localparam int ZF_POS = 6;
  localparam int SF_POS = 7;
  localparam int TF_POS = 8;
  localparam int IF_POS = 9;
  localparam int DF_POS = 10;
  localparam int OF_POS = 11;
  localparam int NIBBLE_W = 4;

  typedef enum logic [3:0] {
    OP_ADD  = 4'd0,
    OP_SUB  = 4'd1,
    OP_INC  = 4'd2,
    OP_DEC  = 4'd3,
    OP_NOT  = 4'd4,
    OP_AND  = 4'd5,
    OP_OR   = 4'd6,
    OP_XOR  = 4'd7,
    OP_SHL  = 4'd8,
    OP_SHR  = 4'd9,
    OP_SETI = 4'd10,
    OP_CLRI = 4'd11,
    OP_SETT = 4'd12,
    OP_CLRT = 4'd13,
    OP_SETD = 4'd14,
    OP_CLRD = 4'd15
  } aluOp_t;

  typedef enum logic [1:0] {
    CTL_TRAP = 2'd0,
    CTL_INTR = 2'd1,
    CTL_DIR  = 2'd2,
    CTL_NONE = 2'd3
  } ctlSel_t;

  // write strobes from the decoder to the flag register
  typedef struct packed {
    logic    wrZsp;
    logic    wrCarry;
    logic    wrAux;
    logic    wrOvf;
    logic    wrCtl;
    ctlSel_t ctlSel;
    logic    ctlVal;
  } strobes_t;

endpackage

// File: rtl/flag_alu_ctrl.sv
module flag_alu_ctrl
  import flag_alu_pkg::*;
(
  input  logic [3:0] opSel,
  input  logic       flagWe,
  output strobes_t   stb
);

  aluOp_t opCode;

  always_comb begin
    opCode = aluOp_t'(opSel);
    stb = '0;
    stb.ctlSel = CTL_NONE;
    if (flagWe) begin
      case (opCode)
        OP_ADD, OP_SUB: begin
          stb.wrZsp = 1'b1;
          stb.wrCarry = 1'b1;
          stb.wrAux = 1'b1;
          stb.wrOvf = 1'b1;
        end
        OP_INC, OP_DEC: begin
          stb.wrZsp = 1'b1;
          stb.wrAux = 1'b1;
          stb.wrOvf = 1'b1;
        end
        OP_NOT, OP_AND, OP_OR, OP_XOR, OP_SHL, OP_SHR: begin
          stb.wrZsp = 1'b1;
          stb.wrCarry = 1'b1;
          stb.wrOvf = 1'b1;
        end
        OP_SETI, OP_CLRI: begin
          stb.wrCtl = 1'b1;
          stb.ctlSel = CTL_INTR;
          stb.ctlVal = (opCode == OP_SETI);
        end
        OP_SETT, OP_CLRT: begin
          stb.wrCtl = 1'b1;
          stb.ctlSel = CTL_TRAP;
          stb.ctlVal = (opCode == OP_SETT);
        end
        OP_SETD, OP_CLRD: begin
          stb.wrCtl = 1'b1;
          stb.ctlSel = CTL_DIR;
          stb.ctlVal = (opCode == OP_SETD);
        end
        default: stb = stb;
      endcase
    end
  end

endmodule

// File: rtl/flag_alu_dp.sv
module flag_alu_dp
  import flag_alu_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  input  logic [3:0]        opSel,
  input  logic              byteMode,
  input  strobes_t          stb,
  output logic [DATA_W-1:0] result,
  output logic [FLAG_W-1:0] flagWord
);

  localparam int EXT_W = DATA_W + 1;

  logic [DATA_W-1:0] laneMask, aM, bM, otherOp, rawRes;
  logic [EXT_W-1:0]  ext;
  logic              subLike, msbA, msbO, msbR;
  logic              carryNew, auxNew, ovfNew;
  logic              cfQ, pfQ, afQ, zfQ, sfQ, tfQ, ifQ, dfQ, ofQ;
  aluOp_t            opCode;

  function automatic logic topBit(input logic [DATA_W-1:0] v, input logic bm);
    return bm ? v[BYTE_W-1] : v[DATA_W-1];
  endfunction

  always_comb begin
    opCode   = aluOp_t'(opSel);
    laneMask = byteMode ? {{(DATA_W-BYTE_W){1'b0}}, {BYTE_W{1'b1}}} : '1;
    aM       = opA & laneMask;
    bM       = opB & laneMask;
    otherOp  = bM;
    subLike  = 1'b0;
    case (opCode)
      OP_ADD: ext = {1'b0, aM} + {1'b0, bM};
      OP_SUB: begin
        ext = {1'b0, aM} - {1'b0, bM};
        subLike = 1'b1;
      end
      OP_INC: begin
        otherOp = DATA_W'(1);
        ext = {1'b0, aM} + EXT_W'(1);
      end
      OP_DEC: begin
        otherOp = DATA_W'(1);
        ext = {1'b0, aM} - EXT_W'(1);
        subLike = 1'b1;
      end
      OP_NOT: ext = {1'b0, ~aM};
      OP_AND: ext = {1'b0, aM & bM};
      OP_OR:  ext = {1'b0, aM | bM};
      OP_XOR: ext = {1'b0, aM ^ bM};
      OP_SHL: ext = {aM, 1'b0};
      OP_SHR: ext = {2'b00, aM[DATA_W-1:1]};
      default: ext = '0;
    endcase
    rawRes = ext[DATA_W-1:0] & laneMask;
    msbA   = topBit(aM, byteMode);
    msbO   = topBit(otherOp, byteMode);
    msbR   = topBit(rawRes, byteMode);
    auxNew = aM[NIBBLE_W] ^ otherOp[NIBBLE_W] ^ rawRes[NIBBLE_W];
    case (opCode)
      OP_ADD, OP_SUB, OP_INC, OP_DEC: begin
        carryNew = byteMode ? ext[BYTE_W] : ext[DATA_W];
        ovfNew   = subLike ? ((msbA != msbO) && (msbR != msbA))
                           : ((msbA == msbO) && (msbR != msbA));
      end
      OP_SHL: begin
        carryNew = msbA;
        ovfNew   = msbR ^ msbA;
      end
      OP_SHR: begin
        carryNew = aM[0];
        ovfNew   = msbA;
      end
      default: begin
        carryNew = 1'b0;
        ovfNew   = 1'b0;
      end
    endcase
  end

  assign result = rawRes;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfQ <= 1'b0; pfQ <= 1'b0; afQ <= 1'b0;
      zfQ <= 1'b0; sfQ <= 1'b0; ofQ <= 1'b0;
      tfQ <= 1'b0; ifQ <= 1'b0; dfQ <= 1'b0;
    end else begin
      if (stb.wrZsp) begin
        zfQ <= (rawRes == '0);
        sfQ <= msbR;
        pfQ <= ~^rawRes[7:0];
      end
      if (stb.wrCarry) cfQ <= carryNew;
      if (stb.wrAux)   afQ <= auxNew;
      if (stb.wrOvf)   ofQ <= ovfNew;
      if (stb.wrCtl) begin
        case (stb.ctlSel)
          CTL_TRAP: tfQ <= stb.ctlVal;
          CTL_INTR: ifQ <= stb.ctlVal;
          CTL_DIR:  dfQ <= stb.ctlVal;
          default:  tfQ <= tfQ;
        endcase
      end
    end
  end

  always_comb begin
    flagWord         = '0;
    flagWord[CF_POS] = cfQ;
    flagWord[PF_POS] = pfQ;
    flagWord[AF_POS] = afQ;
    flagWord[ZF_POS] = zfQ;
    flagWord[SF_POS] = sfQ;
    flagWord[TF_POS] = tfQ;
    flagWord[IF_POS] = ifQ;
    flagWord[DF_POS] = dfQ;
    flagWord[OF_POS] = ofQ;
  end

endmodule

// File: rtl/flag_alu.sv
module flag_alu
  import flag_alu_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  input  logic [3:0]        opSel,
  input  logic              byteMode,
  input  logic              flagWe,
  output logic [DATA_W-1:0] result,
  output logic [FLAG_W-1:0] flagWord
);

  strobes_t stb;

  flag_alu_ctrl u_ctrl (
    .opSel  (opSel),
    .flagWe (flagWe),
    .stb    (stb)
  );

  flag_alu_dp #(.DATA_W(DATA_W), .BYTE_W(BYTE_W)) u_dp (
    .clk      (clk),
    .rst_n    (rst_n),
    .opA      (opA),
    .opB      (opB),
    .opSel    (opSel),
    .byteMode (byteMode),
    .stb      (stb),
    .result   (result),
    .flagWord (flagWord)
  );

endmodule

// File: rtl/flag_alu_chk.sv
module flag_alu_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [3:0]  opSel,
  input logic        byteMode,
  input logic        flagWe,
  input logic [15:0] result,
  input logic [15:0] flagWord
);

  // R1
  undef_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flagWord[1] | flagWord[3] | flagWord[5] | (|flagWord[15:12])) == 1'b0);

  // R2
  hold_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !flagWe |=> $stable(flagWord));

  // R3
  incdec_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flagWe && (opSel == 4'd2 || opSel == 4'd3)) |=> flagWord[0] == $past(flagWord[0]));

  // R6
  zero_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flagWe && opSel < 4'd10) |=> flagWord[6] == ($past(result) == 16'h0));

  // R6
  parity_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flagWe && opSel < 4'd10) |=> flagWord[2] == ($countones($past(result[7:0])) % 2 == 0));

  // R7
  logic_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flagWe && opSel >= 4'd4 && opSel <= 4'd7) |=> (!flagWord[0] && !flagWord[11]));

  // R7
  logic_aux_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flagWe && opSel >= 4'd4 && opSel <= 4'd7) |=> flagWord[4] == $past(flagWord[4]));

  // R9
  byte_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
    byteMode |-> result[15:8] == 8'h00);

  // R10
  set_intr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flagWe && opSel == 4'd10) |=> flagWord[9]);

  // R10
  ctl_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flagWe && opSel >= 4'd10) |=> (flagWord[7:0] == $past(flagWord[7:0]) && flagWord[11] == $past(flagWord[11])));

endmodule

bind flag_alu flag_alu_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .opSel    (opSel),
  .byteMode (byteMode),
  .flagWe   (flagWe),
  .result   (result),
  .flagWord (flagWord)
);

// File: tb/flag_alu_tb.sv
module flag_alu_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] opA = '0, opB = '0;
  logic [3:0]  opSel = '0;
  logic        byteMode = 1'b0, flagWe = 1'b0;
  logic [15:0] result, flagWord;

  int checks = 0;
  int fails = 0;
  logic [15:0] expF = '0;
  int seed = 32'h1234_5678;

  always #4 clk = ~clk;

  flag_alu u_dut (
    .clk(clk), .rst_n(rst_n), .opA(opA), .opB(opB), .opSel(opSel),
    .byteMode(byteMode), .flagWe(flagWe), .result(result), .flagWord(flagWord)
  );

  function automatic int sx(input int v, input int w);
    return (v >= (1 << (w - 1))) ? v - (1 << w) : v;
  endfunction

  function automatic string reqOf(input logic [3:0] op, input logic bm);
    if (bm) return "R9";
    if (op <= 4'd3) return "R3/R4/R5/R6";
    if (op <= 4'd7) return "R7";
    if (op <= 4'd9) return "R8";
    return "R10";
  endfunction

  // reference behaviour computed from the requirements
  task automatic model(input logic [15:0] a, input logic [15:0] b, input logic [3:0] op,
                       input logic bm, input logic [15:0] fIn,
                       output logic [15:0] res, output logic [15:0] fOut);
    int w, mask, ua, ub, r, sr;
    logic cf, af, of;
    w = bm ? 8 : 16;
    mask = (1 << w) - 1;
    ua = int'(a) & mask;
    ub = int'(b) & mask;
    cf = fIn[0]; af = fIn[4]; of = fIn[11];
    fOut = fIn;
    r = 0;
    case (op)
      4'd0: begin r = ua + ub; cf = ((r >> w) & 1) == 1; af = ((ua & 15) + (ub & 15)) > 15;
              sr = sx(ua, w) + sx(ub, w); end
      4'd1: begin r = ua - ub; cf = ua < ub; af = (ua & 15) < (ub & 15);
              sr = sx(ua, w) - sx(ub, w); end
      4'd2: begin r = ua + 1; af = (ua & 15) == 15; sr = sx(ua, w) + 1; end
      4'd3: begin r = ua - 1; af = (ua & 15) == 0; sr = sx(ua, w) - 1; end
      4'd4: r = ~ua;
      4'd5: r = ua & ub;
      4'd6: r = ua | ub;
      4'd7: r = ua ^ ub;
      4'd8: r = ua << 1;
      4'd9: r = ua >> 1;
      default: r = 0;
    endcase
    r = r & mask;
    if (op <= 4'd3) of = (sr > (1 << (w - 1)) - 1) || (sr < -(1 << (w - 1)));
    else if (op <= 4'd7) begin cf = 1'b0; of = 1'b0; end
    else if (op == 4'd8) begin cf = ((ua >> (w - 1)) & 1) == 1; of = ((r ^ ua) >> (w - 1) & 1) == 1; end
    else if (op == 4'd9) begin cf = (ua & 1) == 1; of = ((ua >> (w - 1)) & 1) == 1; end
    if (op <= 4'd9) begin
      fOut[0] = cf; fOut[4] = af; fOut[11] = of;
      fOut[2] = ($countones(r[7:0]) % 2) == 0;
      fOut[6] = (r == 0);
      fOut[7] = ((r >> (w - 1)) & 1) == 1;
    end else begin
      r = 0;
      case (op)
        4'd10: fOut[9] = 1'b1;
        4'd11: fOut[9] = 1'b0;
        4'd12: fOut[8] = 1'b1;
        4'd13: fOut[8] = 1'b0;
        4'd14: fOut[10] = 1'b1;
        default: fOut[10] = 1'b0;
      endcase
    end
    res = r[15:0];
  endtask

  task automatic step(input logic [15:0] a, input logic [15:0] b, input logic [3:0] op,
                      input logic bm, input logic we);
    logic [15:0] expR, nextF;
    opA = a; opB = b; opSel = op; byteMode = bm; flagWe = we;
    model(a, b, op, bm, expF, expR, nextF);
    #1;
    checks++;
    if (result !== expR) begin
      fails++;
      $display("FAIL %s result op=%0d a=%h b=%h bm=%0d: actual %h expected %h",
               reqOf(op, bm), op, a, b, bm, result, expR);
    end
    @(posedge clk);
    #1;
    if (we) expF = nextF;
    checks++;
    if (flagWord !== expF) begin
      fails++;
      $display("FAIL %s flags op=%0d a=%h b=%h bm=%0d we=%0d: actual %h expected %h",
               we ? reqOf(op, bm) : "R2", op, a, b, bm, we, flagWord, expF);
    end
    @(negedge clk);
  endtask

  function automatic int nextRand(input int s);
    int x;
    x = s;
    x = x ^ (x << 13);
    x = x ^ (x >>> 17);
    x = x ^ (x << 5);
    return x;
  endfunction

  initial begin
    #(8 * 190000);
    fails++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [15:0] bSet [16];
    bSet = '{16'h00, 16'h01, 16'h0F, 16'h10, 16'h7F, 16'h80, 16'hFF, 16'h55,
             16'hAA, 16'h08, 16'h81, 16'hFE, 16'h33, 16'h40, 16'hF0, 16'h3C};
    repeat (3) @(negedge clk);
    // R1: reset state
    checks++;
    if (flagWord !== 16'h0000) begin
      fails++;
      $display("FAIL R1 reset flags: actual %h expected 0000", flagWord);
    end
    rst_n = 1'b1;
    @(negedge clk);

    // R10: control flag commands
    for (int op = 10; op < 16; op++) step(16'h1234, 16'h4321, 4'(op), 1'b0, 1'b1);
    step(16'h0, 16'h0, 4'd10, 1'b0, 1'b1);
    step(16'h0, 16'h0, 4'd12, 1'b0, 1'b1);
    step(16'h0, 16'h0, 4'd14, 1'b0, 1'b1);

    // R9 with R3..R8: byte mode sweep, upper bytes carry junk
    for (int a = 0; a < 256; a++)
      for (int bi = 0; bi < 16; bi++)
        for (int op = 0; op < 10; op++)
          step({8'hA5, 8'(a)}, {8'h5A, bSet[bi][7:0]}, 4'(op), 1'b1, 1'b1);

    // R3..R8: word mode with pseudo-random and corner operands
    step(16'h7FFF, 16'h0001, 4'd0, 1'b0, 1'b1);
    step(16'h8000, 16'h0001, 4'd1, 1'b0, 1'b1);
    step(16'hFFFF, 16'h0001, 4'd0, 1'b0, 1'b1);
    step(16'h7FFF, 16'h0000, 4'd2, 1'b0, 1'b1);
    step(16'h8000, 16'h0000, 4'd3, 1'b0, 1'b1);
    step(16'h8001, 16'h0000, 4'd8, 1'b0, 1'b1);
    step(16'h0001, 16'h0000, 4'd9, 1'b0, 1'b1);
    for (int i = 0; i < 1500; i++) begin
      logic [15:0] ra, rb;
      seed = nextRand(seed); ra = seed[15:0]; rb = seed[31:16];
      for (int op = 0; op < 10; op++) step(ra, rb, 4'(op), 1'b0, 1'b1);
    end

    // R2: flag-update enable low leaves every flag alone
    step(16'hFFFF, 16'h0001, 4'd0, 1'b0, 1'b1);
    for (int op = 0; op < 16; op++) step(16'h0000, 16'h0000, 4'(op), 1'b0, 1'b0);
    for (int op = 0; op < 16; op++) step(16'h8000, 16'h8000, 4'(op), 1'b1, 1'b0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule